// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single reservation that one hardware thread uses for atomic read-modify-write sequences built from load-and-reserve and store-conditional instructions. It watches decoded instruction events: a 10-bit extended opcode, a 64-bit effective address, a 2-bit access kind and a valid strobe. A load-and-reserve at byte, halfword or doubleword size records a reservation made of a valid flag, a length in bytes and an address. A store-conditional is checked against that reservation.

For every store-conditional the monitor returns a registered result one cycle later. The result has a pass flag, a store enable for the memory port, and the 4-bit condition field that software reads back. The reservation is dropped by every store-conditional, whether it passes or fails, and by an external clear input that stands in for a coherence invalidation. A store-conditional passes only when the reservation is valid, has the same length as the store and has the same address.

Top module: `lrsc_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `res_valid`, `res_pass`, `res_store_en` and `res_cr0` are 0, and the reservation is invalid: a store-conditional issued first after reset fails.
- R2: An event with `ev_kind` = 2'b01 (load) and opcode 52, 116 or 84 is a load-and-reserve of 1, 2 or 8 bytes. It makes the reservation valid and records its length and `ev_addr`.
- R3: An event with `ev_kind` = 2'b10 (store) and opcode 694, 726 or 214 is a store-conditional of 1, 2 or 8 bytes. It passes only if the reservation is valid and holds the same address.
- R4: A store-conditional whose byte size differs from the recorded length fails, even at the same address.
- R5: Every store-conditional, passing or failing, leaves the reservation invalid.
- R6: `res_cr0` is {2'b00, pass, so} on a result cycle, where so is the `so_bit` value sampled with the store-conditional: 4'b0010 on success and 4'b0000 on failure, with bit 0 set by `so_bit`.
- R7: `res_store_en` is high exactly when `res_pass` is high, in the same cycle.
- R8: `res_valid` is high for exactly one cycle, in the cycle after each store-conditional event, and is low otherwise. When it is low, `res_pass`, `res_store_en` and `res_cr0` are 0.
- R9: Events with other opcodes (for example 87 or 215), events whose `ev_kind` does not match the opcode class, and events with `ev_valid` low leave the reservation unchanged.
- R10: A new load-and-reserve replaces any existing reservation, both length and address.
- R11: `rsv_clear` drops the reservation at the next edge. If it comes in the same cycle as a load-and-reserve, the new reservation is kept. A store-conditional in the same cycle as `rsv_clear` is still judged against the reservation held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Instruction event strobe |
| ev_xop | input | 10 | Extended opcode of the event |
| ev_kind | input | 2 | Access kind: 01 load, 10 store |
| ev_addr | input | 64 | Effective address |
| so_bit | input | 1 | Summary-overflow bit merged into the condition field |
| rsv_clear | input | 1 | External invalidation of the reservation |
| res_valid | output | 1 | One-cycle strobe for a store-conditional result |
| res_pass | output | 1 | Store-conditional succeeded |
| res_store_en | output | 1 | Enable for the memory write of the store |
| res_cr0 | output | 4 | Condition field value |

## Verification
The hardest case to reach is the one where several things meet in the same cycle: a load-and-reserve together with `rsv_clear`, or a store-conditional together with `rsv_clear`, followed directly by a store-conditional of a different size to the same address. Random stimulus rarely lines these up at a matching address. The bench therefore runs directed back-to-back sequences for each of them, and then a long random phase. That phase draws addresses from a pool of four values and opcodes from a list weighted toward the six reservation opcodes, so matches, size mismatches and clears happen often. A behavioural model tracks the reservation and is compared with the outputs on every clock.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int XOP_W  = 10;
    localparam int KIND_W = 2;
    localparam int LEN_W  = 4;

    localparam logic [KIND_W-1:0] KIND_LOAD  = 2'b01;
    localparam logic [KIND_W-1:0] KIND_STORE = 2'b10;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_LR   = 2'd1,
        CMD_SC   = 2'd2
    } cmd_e;

    typedef struct packed {
        cmd_e             op;
        logic [LEN_W-1:0] len;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [XOP_W-1:0] xop,
                                        input logic [KIND_W-1:0] kind);
        cmd_t c;
        c.op  = CMD_NONE;
        c.len = '0;
        case (xop)
            10'd52:  begin c.op = CMD_LR; c.len = 4'd1; end
            10'd116: begin c.op = CMD_LR; c.len = 4'd2; end
            10'd84:  begin c.op = CMD_LR; c.len = 4'd8; end
            10'd694: begin c.op = CMD_SC; c.len = 4'd1; end
            10'd726: begin c.op = CMD_SC; c.len = 4'd2; end
            10'd214: begin c.op = CMD_SC; c.len = 4'd8; end
            default: begin c.op = CMD_NONE; c.len = '0; end
        endcase
        if ((c.op == CMD_LR && kind != KIND_LOAD) ||
            (c.op == CMD_SC && kind != KIND_STORE)) begin
            c.op  = CMD_NONE;
            c.len = '0;
        end
        return c;
    endfunction

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic              valid,
    input  logic [XOP_W-1:0]  xop,
    input  logic [KIND_W-1:0] kind,
    output cmd_t              cmd
);
    always_comb begin
        cmd = decode_cmd(xop, kind);
        if (!valid) begin
            cmd.op  = CMD_NONE;
            cmd.len = '0;
        end
    end
endmodule

// File: rtl/lrsc_rsv_reg.sv
module lrsc_rsv_reg
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clear,
    output logic              rsv_valid,
    output logic [LEN_W-1:0]  rsv_len,
    output logic [ADDR_W-1:0] rsv_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_valid <= 1'b0;
            rsv_len   <= '0;
            rsv_addr  <= '0;
        end else if (cmd.op == CMD_LR) begin
            rsv_valid <= 1'b1;
            rsv_len   <= cmd.len;
            rsv_addr  <= addr;
        end else if (cmd.op == CMD_SC || clear) begin
            rsv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_result.sv
module lrsc_result
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              so_bit,
    input  logic              rsv_valid,
    input  logic [LEN_W-1:0]  rsv_len,
    input  logic [ADDR_W-1:0] rsv_addr,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_store_en,
    output logic [3:0]        res_cr0
);
    logic is_sc;
    logic hit;

    always_comb begin
        is_sc = (cmd.op == CMD_SC);
        hit   = is_sc && rsv_valid && (rsv_len == cmd.len) && (rsv_addr == addr);
    end

    always_ff @(posedge clk) begin
        if (rst || !is_sc) begin
            res_valid    <= 1'b0;
            res_pass     <= 1'b0;
            res_store_en <= 1'b0;
            res_cr0      <= 4'b0000;
        end else begin
            res_valid    <= 1'b1;
            res_pass     <= hit;
            res_store_en <= hit;
            res_cr0      <= {2'b00, hit, so_bit};
        end
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [9:0]        ev_xop,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              so_bit,
    input  logic              rsv_clear,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_store_en,
    output logic [3:0]        res_cr0
);
    cmd_t              cmd;
    logic              rsv_valid;
    logic [LEN_W-1:0]  rsv_len;
    logic [ADDR_W-1:0] rsv_addr;

    lrsc_decode u_dec (
        .valid (ev_valid),
        .xop   (ev_xop),
        .kind  (ev_kind),
        .cmd   (cmd)
    );

    lrsc_rsv_reg #(.ADDR_W(ADDR_W)) u_rsv (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr      (ev_addr),
        .clear     (rsv_clear),
        .rsv_valid (rsv_valid),
        .rsv_len   (rsv_len),
        .rsv_addr  (rsv_addr)
    );

    lrsc_result #(.ADDR_W(ADDR_W)) u_res (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .addr         (ev_addr),
        .so_bit       (so_bit),
        .rsv_valid    (rsv_valid),
        .rsv_len      (rsv_len),
        .rsv_addr     (rsv_addr),
        .res_valid    (res_valid),
        .res_pass     (res_pass),
        .res_store_en (res_store_en),
        .res_cr0      (res_cr0)
    );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_valid,
    input logic [9:0] ev_xop,
    input logic [1:0] ev_kind,
    input logic       so_bit,
    input logic       rsv_clear,
    input logic       rsv_valid,
    input logic       res_valid,
    input logic       res_pass,
    input logic       res_store_en,
    input logic [3:0] res_cr0
);
    logic sc_ev;
    logic lr_ev;

    always_comb begin
        sc_ev = ev_valid && ev_kind == 2'b10 &&
                (ev_xop == 10'd694 || ev_xop == 10'd726 || ev_xop == 10'd214);
        lr_ev = ev_valid && ev_kind == 2'b01 &&
                (ev_xop == 10'd52 || ev_xop == 10'd116 || ev_xop == 10'd84);
    end

    assert_pass_needs_rsv_R3: assert property (@(posedge clk) disable iff (rst)
        res_pass |-> $past(rsv_valid));

    assert_sc_clears_R5: assert property (@(posedge clk) disable iff (rst)
        sc_ev |=> !rsv_valid);

    assert_cr0_shape_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_cr0[3:2] == 2'b00 && res_cr0[1] == res_pass));

    assert_cr0_so_R6: assert property (@(posedge clk) disable iff (rst)
        sc_ev |=> res_cr0[0] == $past(so_bit));

    assert_store_en_R7: assert property (@(posedge clk) disable iff (rst)
        res_store_en == res_pass);

    assert_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        sc_ev |=> res_valid);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_pass && res_cr0 == 4'b0000));

    assert_lr_sets_R2: assert property (@(posedge clk) disable iff (rst)
        lr_ev |=> rsv_valid);

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (rsv_clear && !lr_ev) |=> !rsv_valid);
endmodule

bind lrsc_monitor lrsc_monitor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (ev_valid),
    .ev_xop       (ev_xop),
    .ev_kind      (ev_kind),
    .so_bit       (so_bit),
    .rsv_clear    (rsv_clear),
    .rsv_valid    (rsv_valid),
    .res_valid    (res_valid),
    .res_pass     (res_pass),
    .res_store_en (res_store_en),
    .res_cr0      (res_cr0)
);

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        ev_valid;
    logic [9:0]  ev_xop;
    logic [1:0]  ev_kind;
    logic [63:0] ev_addr;
    logic        so_bit;
    logic        rsv_clear;
    logic        res_valid, res_pass, res_store_en;
    logic [3:0]  res_cr0;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_valid;
    int          m_len;
    logic [63:0] m_addr;

    always #2.5 clk = ~clk;

    lrsc_monitor uut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_xop(ev_xop),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .so_bit(so_bit),
        .rsv_clear(rsv_clear), .res_valid(res_valid), .res_pass(res_pass),
        .res_store_en(res_store_en), .res_cr0(res_cr0)
    );

    function automatic int lr_len(input int x);
        if (x == 52) return 1;
        if (x == 116) return 2;
        if (x == 84) return 8;
        return 0;
    endfunction

    function automatic int sc_len(input int x);
        if (x == 694) return 1;
        if (x == 726) return 2;
        if (x == 214) return 8;
        return 0;
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: {valid,pass,st_en,cr0} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one event at a negedge, model it, compare after the following posedge.
    task automatic step(input string req, input bit v, input int xop, input logic [1:0] kind,
                        input logic [63:0] a, input bit so, input bit clr);
        bit is_lr, is_sc, pass;
        int l;
        logic [6:0] exp;
        ev_valid = v; ev_xop = xop[9:0]; ev_kind = kind; ev_addr = a;
        so_bit = so; rsv_clear = clr;
        is_lr = v && kind == 2'b01 && lr_len(xop) != 0;
        is_sc = v && kind == 2'b10 && sc_len(xop) != 0;
        l = is_lr ? lr_len(xop) : sc_len(xop);
        pass = is_sc && m_valid && m_len == l && m_addr == a;
        exp = is_sc ? {1'b1, pass, pass, 2'b00, pass, so} : 7'b0;
        if (is_lr) begin
            m_valid = 1; m_len = l; m_addr = a;
        end else if (is_sc || clr) begin
            m_valid = 0;
        end
        @(posedge clk);
        #1;
        check(req, {res_valid, res_pass, res_store_en, res_cr0}, exp);
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 2'b00, 64'h0, 0, 0);
    endtask

    localparam logic [63:0] A0 = 64'h0000_1000_0000_0040;
    localparam logic [63:0] A1 = 64'hFFFF_0000_1234_5678;

    initial begin
        rst = 1; ev_valid = 0; ev_xop = 0; ev_kind = 0; ev_addr = 0;
        so_bit = 0; rsv_clear = 0;
        m_valid = 0; m_len = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {res_valid, res_pass, res_store_en, res_cr0}, 7'b0);
        @(negedge clk);
        rst = 0;
        idle("R1 after reset");
        // R1: first SC after reset fails
        step("R1 sc after reset", 1, 694, 2'b10, 64'h0, 0, 0);
        // R2/R3: each size passes
        step("R2 lr byte", 1, 52, 2'b01, A0, 0, 0);
        step("R3 sc byte pass", 1, 694, 2'b10, A0, 0, 0);
        step("R2 lr half", 1, 116, 2'b01, A1, 0, 0);
        step("R3 sc half pass", 1, 726, 2'b10, A1, 0, 0);
        step("R2 lr dword", 1, 84, 2'b01, A0, 0, 0);
        step("R6 sc dword pass with so", 1, 214, 2'b10, A0, 1, 0);
        // R3 address mismatch
        step("R2 lr", 1, 84, 2'b01, A0, 0, 0);
        step("R3 sc wrong addr", 1, 214, 2'b10, A1, 0, 0);
        // R4 size mismatch, then R5 cleared after failure
        step("R2 lr", 1, 116, 2'b01, A0, 0, 0);
        step("R4 sc byte on half rsv", 1, 694, 2'b10, A0, 1, 0);
        step("R5 sc after failed sc", 1, 726, 2'b10, A0, 0, 0);
        // R5 cleared after pass
        step("R2 lr", 1, 52, 2'b01, A1, 0, 0);
        step("R5 first sc", 1, 694, 2'b10, A1, 0, 0);
        step("R5 second sc fails", 1, 694, 2'b10, A1, 0, 0);
        // R9 other opcodes and kind mismatch do not touch reservation
        step("R2 lr", 1, 84, 2'b01, A0, 0, 0);
        step("R9 op87", 1, 87, 2'b01, A1, 0, 0);
        step("R9 op215", 1, 215, 2'b10, A1, 0, 0);
        step("R9 sc opcode as load kind", 1, 214, 2'b01, A0, 0, 0);
        step("R9 lr opcode as store kind", 1, 52, 2'b10, A1, 0, 0);
        step("R9 invalid strobe", 0, 214, 2'b10, A0, 0, 0);
        step("R9 reservation intact", 1, 214, 2'b10, A0, 0, 0);
        // R10 replace
        step("R2 lr", 1, 84, 2'b01, A0, 0, 0);
        step("R10 new lr", 1, 116, 2'b01, A1, 0, 0);
        step("R10 old rsv gone", 1, 214, 2'b10, A0, 0, 0);
        step("R10 lr", 1, 84, 2'b01, A0, 0, 0);
        step("R10 lr2", 1, 116, 2'b01, A1, 0, 0);
        step("R10 new rsv holds", 1, 726, 2'b10, A1, 0, 0);
        // R11 clear
        step("R2 lr", 1, 52, 2'b01, A0, 0, 0);
        step("R11 clear", 0, 0, 2'b00, A0, 0, 1);
        step("R11 sc after clear", 1, 694, 2'b10, A0, 0, 0);
        step("R11 lr with clear", 1, 52, 2'b01, A0, 0, 1);
        step("R11 lr wins", 1, 694, 2'b10, A0, 0, 0);
        step("R2 lr", 1, 116, 2'b01, A1, 0, 0);
        step("R11 sc with clear same cycle", 1, 726, 2'b10, A1, 1, 1);
        idle("R8 idle no strobe");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int ops[10] = '{52, 116, 84, 694, 726, 214, 87, 215, 694, 52};
            logic [63:0] pool[4] = '{A0, A1, A0 + 64'd1, 64'h0};
            int x;
            logic [1:0] k;
            x = ops[$urandom_range(0, 9)];
            k = (sc_len(x) != 0 || x == 215) ? 2'b10 : 2'b01;
            if ($urandom_range(0, 15) == 0) k = ~k;
            step("R8 random", $urandom_range(0, 7) != 0, x, k,
                 pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)),
                 $urandom_range(0, 9) == 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule